// File: doc/BRIEF.md
# Table-Lookup Element Permutation Unit

This block performs a constant-time table lookup inside a single register-width word. One operand, the table, is viewed as a packed vector of small elements; the other operand, the selector, is viewed as a packed vector of indices of the same element size. Every selector element is replaced by the table element it names. An index that points past the last table element produces zero for that position.

Two element sizes are supported, chosen per operation by a one-bit size input: 4-bit elements and 8-bit elements. The unit is purely combinational with no early exit. Its delay is therefore the same for every data pattern, which makes it suitable for substitution tables in code whose timing must not leak secret data. Instruction decode and register-file access sit outside this block.

Top module: `xbar_perm_unit`

## Requirements
- R1: With `byte_mode_i` = 0, result bits [4k+3:4k] equal table element j = bits [4j+3:4j] of `tbl_i`, where j is the value of `idx_i` bits [4k+3:4k], whenever j < XLEN/4.
- R2: With `byte_mode_i` = 1, result bits [8k+7:8k] equal table bits [8j+7:8j], where j is the value of `idx_i` bits [8k+7:8k], whenever j < XLEN/8.
- R3: In 4-bit mode, a selector element with value at or above XLEN/4 gives a zero nibble. For XLEN = 32 this means values 8 to 15.
- R4: In 8-bit mode, a selector element with value at or above XLEN/8 gives a zero byte, for every value up to 255.
- R5: The full width of each selector element takes part in the range test. A byte index such as 0x41, whose low bits name a valid element, still gives zero.
- R6: Each result element depends only on its own selector element and the table. The same index placed in every position yields that table element in every position.
- R7: `byte_mode_i` encodes the element size: 0 selects 4-bit elements and 1 selects 8-bit elements. The same operands give the result of the selected size.
- R8: The result is a pure function of the present inputs and holds no state. A change of inputs is visible on `result_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tbl_i | input | XLEN | Packed table of elements |
| idx_i | input | XLEN | Packed selector indices, one per result element |
| byte_mode_i | input | 1 | Element size: 0 = 4-bit, 1 = 8-bit |
| result_o | output | XLEN | Permuted result |

## Verification
The bench builds two copies of the unit, one with XLEN = 64 and one with XLEN = 32, and drives both from the same operands. Only the 32-bit build can produce out-of-range nibble indices (8 to 15), because all 16 nibble values are valid indices at XLEN = 64. The 64-bit build covers the full table of eight bytes and byte indices whose low three bits alias a valid slot, so a range test that looks at too few bits shows up there.

// File: rtl/xbar_perm_pkg.sv
package xbar_perm_pkg;

  // Element-size selector encoding; bit value is part of the block's contract.
  typedef enum logic {
    ELEM_NIBBLE = 1'b0,
    ELEM_BYTE   = 1'b1
  } elem_size_e;

  localparam int unsigned NIBBLE_W = 4;
  localparam int unsigned BYTE_W   = 8;

endpackage

// File: rtl/xbar_perm_lane.sv
// One result element: select a table element by shifting the whole table.
// A shift amount past the table width naturally yields zero, so the range
// test costs no extra comparator and the path has fixed depth.
module xbar_perm_lane #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned EW   = 4
) (
  input  logic [XLEN-1:0] tbl_i,
  input  logic [EW-1:0]   idx_i,
  output logic [EW-1:0]   elem_o
);

  localparam int unsigned EW_LOG = $clog2(EW);
  localparam int unsigned SHW    = EW + EW_LOG;

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] shifted;

  always_comb begin
    shamt   = {idx_i, {EW_LOG{1'b0}}};
    shifted = tbl_i >> shamt;
    elem_o  = shifted[EW-1:0];
  end

endmodule

// File: rtl/xbar_perm_lanes.sv
// Full-width permutation at one fixed element size.
module xbar_perm_lanes #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned EW   = 4
) (
  input  logic [XLEN-1:0] tbl_i,
  input  logic [XLEN-1:0] idx_i,
  output logic [XLEN-1:0] perm_o
);

  localparam int unsigned NELEM = XLEN / EW;

  for (genvar k = 0; k < NELEM; k++) begin : g_lane
    xbar_perm_lane #(
      .XLEN (XLEN),
      .EW   (EW)
    ) lane_i (
      .tbl_i  (tbl_i),
      .idx_i  (idx_i[k*EW +: EW]),
      .elem_o (perm_o[k*EW +: EW])
    );
  end

endmodule

// File: rtl/xbar_perm_unit.sv
// Top: both element sizes evaluated in parallel, final select by size bit.
module xbar_perm_unit
  import xbar_perm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] tbl_i,
  input  logic [XLEN-1:0] idx_i,
  input  logic            byte_mode_i,
  output logic [XLEN-1:0] result_o
);

  logic [XLEN-1:0] nib_res;
  logic [XLEN-1:0] byte_res;
  elem_size_e      size_sel;

  xbar_perm_lanes #(
    .XLEN (XLEN),
    .EW   (NIBBLE_W)
  ) nib_perm_i (
    .tbl_i  (tbl_i),
    .idx_i  (idx_i),
    .perm_o (nib_res)
  );

  xbar_perm_lanes #(
    .XLEN (XLEN),
    .EW   (BYTE_W)
  ) byte_perm_i (
    .tbl_i  (tbl_i),
    .idx_i  (idx_i),
    .perm_o (byte_res)
  );

  always_comb begin
    size_sel = elem_size_e'(byte_mode_i);
    case (size_sel)
      ELEM_BYTE: result_o = byte_res;
      default:   result_o = nib_res;
    endcase
  end

endmodule

// File: rtl/xbar_perm_chk.sv
// Port-level checker; the unit has no clock, so checks are immediate.
module xbar_perm_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic [XLEN-1:0] tbl_i,
  input logic [XLEN-1:0] idx_i,
  input logic            byte_mode_i,
  input logic [XLEN-1:0] result_o
);

  localparam int unsigned NN = XLEN / 4;
  localparam int unsigned NB = XLEN / 8;

  for (genvar k = 0; k < NN; k++) begin : g_nib
    always_comb begin
      if (!byte_mode_i) begin
        if (int'(idx_i[k*4 +: 4]) < NN) begin
          p_nib_lookup_r1: assert (result_o[k*4 +: 4] == tbl_i[int'(idx_i[k*4 +: 4])*4 +: 4]);
        end else begin
          p_nib_oor_zero_r3: assert (result_o[k*4 +: 4] == 4'h0);
        end
      end
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    always_comb begin
      if (byte_mode_i) begin
        if (int'(idx_i[k*8 +: 8]) < NB) begin
          p_byte_lookup_r2: assert (result_o[k*8 +: 8] == tbl_i[int'(idx_i[k*8 +: 8])*8 +: 8]);
        end else begin
          p_byte_oor_zero_r4: assert (result_o[k*8 +: 8] == 8'h00);
        end
      end
    end
  end

endmodule

bind xbar_perm_unit xbar_perm_chk #(.XLEN(XLEN)) chk_i (
  .tbl_i       (tbl_i),
  .idx_i       (idx_i),
  .byte_mode_i (byte_mode_i),
  .result_o    (result_o)
);

// File: tb/xbar_perm_unit_tb_top.sv
module xbar_perm_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [63:0] tbl;
  logic [63:0] idx;
  logic        mode;
  logic [63:0] res64;
  logic [31:0] res32;
  int          checks;
  int          fails;
  bit          done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  xbar_perm_unit #(.XLEN(64)) dut_i (
    .tbl_i       (tbl),
    .idx_i       (idx),
    .byte_mode_i (mode),
    .result_o    (res64)
  );

  xbar_perm_unit #(.XLEN(32)) dut32_i (
    .tbl_i       (tbl[31:0]),
    .idx_i       (idx[31:0]),
    .byte_mode_i (mode),
    .result_o    (res32)
  );

  // Behavioural reference: per element, in-range index picks, else zero.
  function automatic logic [63:0] ref_perm(input logic [63:0] t, input logic [63:0] s,
                                           input int xlen, input int ew);
    logic [63:0] r;
    int cnt;
    int sel;
    r = '0;
    cnt = xlen / ew;
    for (int e = 0; e < cnt; e++) begin
      sel = 0;
      for (int b = 0; b < ew; b++) sel = sel | (int'(s[e*ew + b]) << b);
      if (sel < cnt)
        for (int b = 0; b < ew; b++) r[e*ew + b] = t[sel*ew + b];
    end
    return r;
  endfunction

  task automatic compare(input string tag);
    logic [63:0] e64;
    logic [63:0] e32;
    int ew;
    ew = mode ? 8 : 4;
    e64 = ref_perm(tbl, idx, 64, ew);
    e32 = ref_perm({32'h0, tbl[31:0]}, {32'h0, idx[31:0]}, 32, ew);
    checks++;
    if (res64 !== e64) begin
      fails++;
      $display("FAIL %s xlen64 mode=%0d actual=%h expected=%h", tag, mode, res64, e64);
    end
    checks++;
    if (res32 !== e32[31:0]) begin
      fails++;
      $display("FAIL %s xlen32 mode=%0d actual=%h expected=%h", tag, mode, res32, e32[31:0]);
    end
  endtask

  // Drive just after a rising edge, check at the following falling edge.
  task automatic apply(input logic [63:0] t, input logic [63:0] s, input logic m,
                       input string tag);
    @(posedge clk);
    #1;
    tbl  = t;
    idx  = s;
    mode = m;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    tbl    = '0;
    idx    = '0;
    mode   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands give a zero result
    checks++;
    if (res64 !== 64'h0 || res32 !== 32'h0) begin
      fails++;
      $display("FAIL reset actual=%h/%h expected=0", res64, res32);
    end
    rst_n = 1'b1;

    // R1 identity nibble selector returns the table
    apply(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0, "R1");
    apply(64'hA5C3_0F1E_7766_2B90, 64'h0000_1111_FFFF_8888, 1'b0, "R1");
    // R3 nibble indices 8..15 out of range at XLEN=32
    apply(64'h1357_9BDF_2468_ACE0, 64'h89AB_CDEF_FEDC_BA98, 1'b0, "R3");
    // R2 identity byte selector
    apply(64'h1122_3344_5566_7788, 64'h0706_0504_0302_0100, 1'b1, "R2");
    apply(64'hDEAD_BEEF_CAFE_F00D, 64'h0001_0203_0405_0607, 1'b1, "R2");
    // R4 byte indices past the count, up to 255
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0809_1020_7F80_C0FF, 1'b1, "R4");
    apply(64'h0102_0304_0506_0708, 64'h0405_0607_0004_0106, 1'b1, "R4");
    // R5 aliased high bits must still give zero
    apply(64'h8877_6655_4433_2211, 64'h4142_8388_C1E2_0913, 1'b1, "R5");
    apply(64'h8877_6655_4433_2211, 64'h0A0B_0C0D_0E0F_2324, 1'b1, "R5");
    // R6 broadcast of one index to every position
    apply(64'h0F1E_2D3C_4B5A_6978, 64'h5555_5555_5555_5555, 1'b0, "R6");
    apply(64'h0F1E_2D3C_4B5A_6978, 64'h0202_0202_0202_0202, 1'b1, "R6");
    // R7 same operands under both size encodings
    apply(64'h9A8B_7C6D_5E4F_3021, 64'h0301_0203_0102_0300, 1'b0, "R7");
    apply(64'h9A8B_7C6D_5E4F_3021, 64'h0301_0203_0102_0300, 1'b1, "R7");
    // R8 inputs change every cycle; result tracks without delay
    for (int n = 0; n < 8; n++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, n[0], "R8");
    // random operands, random selectors biased toward small values
    for (int n = 0; n < 400; n++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      if (n % 3 == 0) s = s & 64'h0707_0707_0707_0707;
      apply({$urandom, $urandom}, s, n[1], n[1] ? "R2" : "R1");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule